// File: doc/BRIEF.md
# Bank Select and Address Mapper

This block is the bank-switching front end of a cartridge-style memory system. The CPU writes into a small register set, and the block translates addresses through it. A command register names the bank register that takes the next data write and holds two layout bits. Eight bank registers hold the bank numbers. A one-bit control sets the nametable mirroring. From these registers the block turns a CPU read address in the upper 32 KB, and a 13-bit video pattern address, into physical bank numbers plus in-bank offsets. The memory arrays sit outside the block.

Program space is split into four 8 KB windows. Two of them can trade places under a layout bit, one of them always shows the second-to-last bank, and the top window always shows the last bank. Pattern space is split into eight 1 KB windows. Two registers each cover a 2 KB pair of windows, and a second layout bit exchanges the two 4 KB pattern halves. All outputs are combinational from the registers and the addresses, so a register write shows at the outputs from the clock edge that captures it.

Top module: `bank_mapper`

## Requirements
- R1: After reset, bank registers 0 to 7 hold 0, 2, 4, 5, 6, 7, 0 and 1. The command register reads zero, which means target 0, no layout swap and no pattern inversion. The mirroring control is 0, so `mirror_sel` is 1.
- R2: A write whose address ANDed with 0xE001 equals 0x8000 loads the command register. Data bits 2:0 name the target register, bit 6 is the program-swap bit and bit 7 is the pattern-invert bit.
- R3: A write whose address ANDed with 0xE001 equals 0x8001 stores the data byte into the bank register named by command bits 2:0. Every other bank register is left unchanged. Aliased addresses such as 0x9FFF decode the same way.
- R4: Pattern windows 0x0000, 0x0400, 0x0800 and 0x0C00 map to register 0 with bit 0 cleared, register 0 with bit 0 set, register 1 with bit 0 cleared and register 1 with bit 0 set.
- R5: Pattern windows 0x1000, 0x1400, 0x1800 and 0x1C00 map to registers 2, 3, 4 and 5. `chr_offset` equals video address bits 9:0.
- R6: When the pattern-invert bit is set, the video address is XORed with 0x1000 before the window is chosen.
- R7: With the program-swap bit clear, window 0x8000 maps to register 6 and window 0xC000 maps to bank PRG_BANKS-2. With the bit set, these two windows trade places.
- R8: Window 0xA000 always maps to register 7 and window 0xE000 always maps to bank PRG_BANKS-1. `prg_offset` equals read address bits 12:0.
- R9: A program bank taken from a register uses only its low PRG_BANK_W bits (6 by default).
- R10: A write whose address ANDed with 0xE001 equals 0xA000 latches data bit 0 as the mirroring control, and `mirror_sel` is its inverse.
- R11: A write with any other decode (0xA001, 0xC000 and above, below 0x8000), or any cycle with `wr_en` low, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| rd_addr | input | 16 | CPU read address (0x8000 to 0xFFFF) |
| vid_addr | input | 13 | Video pattern address |
| prg_bank | output | PRG_BANK_W | Physical 8 KB program bank |
| prg_offset | output | 13 | Offset inside the program bank |
| chr_bank | output | 8 | Physical 1 KB pattern bank |
| chr_offset | output | 10 | Offset inside the pattern bank |
| mirror_sel | output | 1 | Nametable mirroring select |

## Verification
The hardest case to reach is pattern inversion combined with a 2 KB pair. To get there, the bench loads register 1 with an odd value, sets the invert bit and probes the upper 4 KB half. The expected bank is the even value of register 1 in one window and the odd value in the next, which tests the XOR and the forced low bit together. Address aliasing is a second hard case. A bank write sent to 0x9FFF must land in the selected register, while writes below 0x8000 and at 0xA001 or 0xC000 must leave that register untouched. The bench checks this by reading window 0xA000 after each of these writes.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

   localparam int DATA_W        = 8;
   localparam int NUM_BANK_REGS = 8;
   localparam int SEL_W         = $clog2(NUM_BANK_REGS);
   localparam int ADDR_W        = 16;
   localparam int VID_W         = 13;

   localparam logic [ADDR_W-1:0] DEC_MASK   = 16'hE001;
   localparam logic [ADDR_W-1:0] DEC_CMD    = 16'h8000;
   localparam logic [ADDR_W-1:0] DEC_BANK   = 16'h8001;
   localparam logic [ADDR_W-1:0] DEC_MIRROR = 16'hA000;

   typedef enum logic [1:0] {
      WK_NONE,
      WK_CMD,
      WK_BANK,
      WK_MIRROR
   } wr_kind_e;

   typedef struct packed {
      logic             chr_inv;
      logic             prg_swap;
      logic [SEL_W-1:0] sel;
   } cmd_t;

   function automatic wr_kind_e decode_write(input logic [ADDR_W-1:0] a);
      logic [ADDR_W-1:0] m;
      m = a & DEC_MASK;
      if (m == DEC_CMD)         return WK_CMD;
      else if (m == DEC_BANK)   return WK_BANK;
      else if (m == DEC_MIRROR) return WK_MIRROR;
      else                      return WK_NONE;
   endfunction

   function automatic logic [DATA_W-1:0] bank_reset_value(input int idx);
      if (idx == 0)      return DATA_W'(0);
      else if (idx == 1) return DATA_W'(2);
      else if (idx < 6)  return DATA_W'(idx + 2);
      else               return DATA_W'(idx - 6);
   endfunction

endpackage

// File: rtl/bm_ctrl_regs.sv
module bm_ctrl_regs
   import bank_map_pkg::*;
(
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_en,
   input  logic [ADDR_W-1:0]                     wr_addr,
   input  logic [DATA_W-1:0]                     wr_data,
   output cmd_t                                  cmd_q,
   output logic [NUM_BANK_REGS-1:0][DATA_W-1:0]  banks_q,
   output logic                                  mirror_q
);

   wr_kind_e kind;
   assign kind = decode_write(wr_addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (wr_en && kind == WK_CMD) begin
         cmd_q.chr_inv  <= wr_data[7];
         cmd_q.prg_swap <= wr_data[6];
         cmd_q.sel      <= wr_data[SEL_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < NUM_BANK_REGS; i++) begin
         if (!rst_n) begin
            banks_q[i] <= bank_reset_value(i);
         end else if (wr_en && kind == WK_BANK && cmd_q.sel == SEL_W'(i)) begin
            banks_q[i] <= wr_data;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mirror_q <= 1'b0;
      end else if (wr_en && kind == WK_MIRROR) begin
         mirror_q <= wr_data[0];
      end
   end

   AST_CMD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && kind == WK_CMD) |=> (cmd_q.sel == $past(wr_data[SEL_W-1:0]) &&
                                     cmd_q.prg_swap == $past(wr_data[6]) &&
                                     cmd_q.chr_inv == $past(wr_data[7]))); // R2

   AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && kind == WK_BANK) |=> (banks_q[$past(cmd_q.sel)] == $past(wr_data))); // R3

   AST_MIRROR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && kind == WK_MIRROR) |=> $stable(mirror_q)); // R10

   AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || kind == WK_NONE) |=> ($stable(cmd_q) && $stable(banks_q))); // R11

endmodule

// File: rtl/bm_prg_xlate.sv
module bm_prg_xlate
   import bank_map_pkg::*;
#(
   parameter int PRG_BANKS  = 32,
   parameter int PRG_BANK_W = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     rd_addr,
   input  logic                  prg_swap,
   input  logic [DATA_W-1:0]     reg_sw,
   input  logic [DATA_W-1:0]     reg_mid,
   output logic [PRG_BANK_W-1:0] prg_bank,
   output logic [12:0]           prg_offset
);

   localparam int NUM_WIN = 4;
   localparam logic [PRG_BANK_W-1:0] LAST_BANK   = PRG_BANK_W'(PRG_BANKS - 1);
   localparam logic [PRG_BANK_W-1:0] SECOND_BANK = PRG_BANK_W'(PRG_BANKS - 2);

   if (PRG_BANKS < 2 || PRG_BANKS > (1 << PRG_BANK_W)) begin : g_bad_banks
      $error("PRG_BANKS must lie between 2 and 2**PRG_BANK_W");
   end
   if (PRG_BANK_W > DATA_W) begin : g_bad_width
      $error("PRG_BANK_W may not exceed the register width");
   end

   logic [PRG_BANK_W-1:0] sw_bank;
   logic [PRG_BANK_W-1:0] mid_bank;
   assign sw_bank  = reg_sw[PRG_BANK_W-1:0];
   assign mid_bank = reg_mid[PRG_BANK_W-1:0];

   if (PRG_BANK_W < DATA_W) begin : g_trim
      logic unused_prg_hi;
      assign unused_prg_hi = ^{reg_sw[DATA_W-1:PRG_BANK_W], reg_mid[DATA_W-1:PRG_BANK_W], rd_addr[15]};
   end else begin : g_notrim
      logic unused_prg_hi;
      assign unused_prg_hi = rd_addr[15];
   end

   logic [NUM_WIN-1:0][PRG_BANK_W-1:0] win_bank;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      if (w == 1) begin : g_mid
         assign win_bank[w] = mid_bank;
      end else if (w == 3) begin : g_last
         assign win_bank[w] = LAST_BANK;
      end else begin : g_swap
         assign win_bank[w] = ((w == 0) ^ prg_swap) ? sw_bank : SECOND_BANK;
      end
   end

   logic [1:0] win;
   assign win        = rd_addr[14:13];
   assign prg_bank   = win_bank[win];
   assign prg_offset = rd_addr[12:0];

   AST_LAST_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (win == 2'd3) |-> (prg_bank == LAST_BANK)); // R8

   AST_SWAP_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      (win == 2'd0 && prg_swap) |-> (prg_bank == SECOND_BANK)); // R7

endmodule

// File: rtl/bm_chr_xlate.sv
module bm_chr_xlate
   import bank_map_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [VID_W-1:0]      vid_addr,
   input  logic                  chr_inv,
   input  logic [5:0][DATA_W-1:0] chr_regs,
   output logic [DATA_W-1:0]     chr_bank,
   output logic [9:0]            chr_offset
);

   localparam int NUM_WIN  = 8;
   localparam int PAIR_WIN = 4;

   logic [VID_W-1:0] eff_addr;
   logic [2:0]       eff_win;
   assign eff_addr = vid_addr ^ {chr_inv, {(VID_W-1){1'b0}}};
   assign eff_win  = eff_addr[12:10];

   logic [NUM_WIN-1:0][DATA_W-1:0] win_bank;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      if (w < PAIR_WIN) begin : g_pair
         assign win_bank[w] = {chr_regs[w / 2][DATA_W-1:1], 1'(w % 2)};
      end else begin : g_single
         assign win_bank[w] = chr_regs[w - 2];
      end
   end

   assign chr_bank   = win_bank[eff_win];
   assign chr_offset = vid_addr[9:0];

   AST_PAIR_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (!eff_win[2]) |-> (chr_bank[0] == eff_win[0])); // R4

   AST_INVERT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_inv && vid_addr[12]) |-> !eff_win[2]); // R6

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
   import bank_map_pkg::*;
#(
   parameter int PRG_BANKS  = 32,
   parameter int PRG_BANK_W = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [15:0]           wr_addr,
   input  logic [7:0]            wr_data,
   input  logic [15:0]           rd_addr,
   input  logic [12:0]           vid_addr,
   output logic [PRG_BANK_W-1:0] prg_bank,
   output logic [12:0]           prg_offset,
   output logic [7:0]            chr_bank,
   output logic [9:0]            chr_offset,
   output logic                  mirror_sel
);

   cmd_t                                 cmd_q;
   logic [NUM_BANK_REGS-1:0][DATA_W-1:0] banks_q;
   logic                                 mirror_q;

   bm_ctrl_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .cmd_q    (cmd_q),
      .banks_q  (banks_q),
      .mirror_q (mirror_q)
   );

   bm_prg_xlate #(
      .PRG_BANKS  (PRG_BANKS),
      .PRG_BANK_W (PRG_BANK_W)
   ) u_prg (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_addr    (rd_addr),
      .prg_swap   (cmd_q.prg_swap),
      .reg_sw     (banks_q[6]),
      .reg_mid    (banks_q[7]),
      .prg_bank   (prg_bank),
      .prg_offset (prg_offset)
   );

   bm_chr_xlate u_chr (
      .clk        (clk),
      .rst_n      (rst_n),
      .vid_addr   (vid_addr),
      .chr_inv    (cmd_q.chr_inv),
      .chr_regs   (banks_q[5:0]),
      .chr_bank   (chr_bank),
      .chr_offset (chr_offset)
   );

   assign mirror_sel = ~mirror_q;

   AST_MIRROR_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && decode_write(wr_addr) == WK_MIRROR) |=> (mirror_sel != $past(wr_data[0]))); // R10

endmodule

// File: tb/tb_bank_mapper.sv
module tb_bank_mapper;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 26;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [15:0] rd_addr = 16'h8000;
   logic [12:0] vid_addr = '0;
   logic [5:0]  prg_bank;
   logic [12:0] prg_offset;
   logic [7:0]  chr_bank;
   logic [9:0]  chr_offset;
   logic        mirror_sel;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bank_mapper #(.PRG_BANKS(32), .PRG_BANK_W(6)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .vid_addr(vid_addr), .prg_bank(prg_bank), .prg_offset(prg_offset),
      .chr_bank(chr_bank), .chr_offset(chr_offset), .mirror_sel(mirror_sel)
   );

   typedef struct packed {
      logic [15:0] wa;
      logic [7:0]  wd;
      logic [15:0] ra;
      logic [12:0] va;
      logic [5:0]  ep;
      logic [7:0]  ec;
      logic [3:0]  rq;
   } vec_t;

   // wa = 0x0000 is an idle write that must decode to nothing (R11)
   localparam vec_t VECS [NV] = '{
      '{16'h0000, 8'h00, 16'h8000, 13'h0000, 6'd0,  8'h00, 4'd1},  // R1
      '{16'h0000, 8'h00, 16'hA000, 13'h0400, 6'd1,  8'h01, 4'd1},  // R1
      '{16'h0000, 8'h00, 16'hC000, 13'h0800, 6'd30, 8'h02, 4'd7},  // R7
      '{16'h0000, 8'h00, 16'hE000, 13'h0C00, 6'd31, 8'h03, 4'd8},  // R8
      '{16'h0000, 8'h00, 16'h8000, 13'h1000, 6'd0,  8'h04, 4'd5},  // R5
      '{16'h0000, 8'h00, 16'hFFFF, 13'h1C00, 6'd31, 8'h07, 4'd5},  // R5
      '{16'h8000, 8'h06, 16'h8000, 13'h1400, 6'd0,  8'h05, 4'd2},  // R2
      '{16'h8001, 8'hC5, 16'h8000, 13'h1800, 6'd5,  8'h06, 4'd9},  // R9
      '{16'h8000, 8'h46, 16'h8000, 13'h0000, 6'd30, 8'h00, 4'd7},  // R7
      '{16'h0000, 8'h00, 16'hC000, 13'h0000, 6'd5,  8'h00, 4'd7},  // R7
      '{16'h8000, 8'h00, 16'hA000, 13'h0000, 6'd1,  8'h00, 4'd2},  // R2
      '{16'h8001, 8'h0B, 16'hE000, 13'h0000, 6'd31, 8'h0A, 4'd4},  // R4
      '{16'h0000, 8'h00, 16'hDFFF, 13'h07FF, 6'd30, 8'h0B, 4'd4},  // R4
      '{16'h8000, 8'h80, 16'h8000, 13'h1000, 6'd5,  8'h0A, 4'd6},  // R6
      '{16'h0000, 8'h00, 16'hA000, 13'h0000, 6'd1,  8'h04, 4'd6},  // R6
      '{16'h8000, 8'h81, 16'h8000, 13'h1400, 6'd5,  8'h0B, 4'd6},  // R6
      '{16'h8001, 8'h21, 16'h8000, 13'h1800, 6'd5,  8'h20, 4'd3},  // R3
      '{16'h0000, 8'h00, 16'h8000, 13'h1C00, 6'd5,  8'h21, 4'd4},  // R4
      '{16'h8000, 8'h07, 16'hA000, 13'h0800, 6'd1,  8'h20, 4'd2},  // R2
      '{16'h8001, 8'h3F, 16'hA000, 13'h0800, 6'd63, 8'h20, 4'd3},  // R3
      '{16'hA001, 8'hFF, 16'hA000, 13'h0C00, 6'd63, 8'h21, 4'd11}, // R11
      '{16'hC000, 8'h12, 16'hA000, 13'h0C00, 6'd63, 8'h21, 4'd11}, // R11
      '{16'h9FFF, 8'h10, 16'hA000, 13'h0000, 6'd16, 8'h0A, 4'd3},  // R3 alias
      '{16'h7FFF, 8'h33, 16'hA000, 13'h0000, 6'd16, 8'h0A, 4'd11}, // R11
      '{16'h8000, 8'h03, 16'hA000, 13'h1400, 6'd16, 8'h05, 4'd2},  // R2
      '{16'h8001, 8'h99, 16'hA000, 13'h1400, 6'd16, 8'h99, 4'd3}   // R3
   };

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic en);
      @(negedge clk);
      wr_en = en; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic probe(input logic [15:0] ra, input logic [12:0] va);
      rd_addr = ra; vid_addr = va;
      #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      probe(16'h8000, 13'h0000);
      check("R1", "mirror_sel after reset", mirror_sel, 1);

      for (int i = 0; i < NV; i++) begin
         string rq;
         rq = $sformatf("R%0d", VECS[i].rq);
         do_write(VECS[i].wa, VECS[i].wd, 1'b1);
         probe(VECS[i].ra, VECS[i].va);
         check(rq, $sformatf("vec %0d prg_bank", i), prg_bank, VECS[i].ep);
         check(rq, $sformatf("vec %0d chr_bank", i), chr_bank, VECS[i].ec);
         check("R8", $sformatf("vec %0d prg_offset", i), prg_offset, VECS[i].ra & 16'h1FFF);
         check("R5", $sformatf("vec %0d chr_offset", i), chr_offset, VECS[i].va & 13'h03FF);
      end

      // Mirroring control: bit 0 only, inverse at the output (R10)
      do_write(16'hA000, 8'h01, 1'b1); probe(16'h8000, 13'h0);
      check("R10", "mirror_sel after bit0=1", mirror_sel, 0);
      do_write(16'hA000, 8'hFE, 1'b1); probe(16'h8000, 13'h0);
      check("R10", "mirror_sel after bit0=0", mirror_sel, 1);
      do_write(16'hA001, 8'h01, 1'b1); probe(16'h8000, 13'h0);
      check("R11", "mirror_sel after 0xA001 write", mirror_sel, 1);
      do_write(16'hBFFE, 8'h01, 1'b1); probe(16'h8000, 13'h0);
      check("R10", "mirror_sel after alias 0xBFFE", mirror_sel, 0);

      // Strobe low: command write must not land (R11); register 3 holds 0x99
      do_write(16'h8000, 8'h46, 1'b0); probe(16'h8000, 13'h1400);
      check("R11", "prg_bank with strobe low", prg_bank, 5);
      check("R11", "chr_bank with strobe low", chr_bank, 8'h99);
      do_write(16'h8001, 8'h55, 1'b0); probe(16'h8000, 13'h1400);
      check("R11", "chr_bank after unstrobed data", chr_bank, 8'h99);

      // Reset in mid run restores defaults (R1)
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      probe(16'h8000, 13'h1400);
      check("R1", "prg_bank after re-reset", prg_bank, 0);
      check("R1", "chr_bank after re-reset", chr_bank, 5);
      check("R1", "mirror_sel after re-reset", mirror_sel, 1);
      probe(16'hC000, 13'h1C00);
      check("R1", "second-to-last after re-reset", prg_bank, 30);
      check("R1", "reg5 after re-reset", chr_bank, 7);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule